// File: doc/BRIEF.md
# Two-phase JK ripple-enable up-counter

This block is a binary up-counter whose every bit is a two-stage JK cell. On the rising clock edge each cell computes its next state from its J and K inputs and holds it in a front (master) stage. On the falling edge that state moves to the back (slave) stage, which drives the visible count. A new count value therefore appears half a clock period after the edge that decided it.

Every cell has J tied to K, so each cell either holds or toggles. Bit 0 toggles whenever counting is enabled. Any higher bit toggles only when counting is enabled and every bit below it is 1. This gives a plain binary increment that wraps from all ones to zero. An active-low clear empties both stages at once, without waiting for a clock edge.

Top module: `jk_ms_counter`

## Requirements
- R1: While `clr_n` is low, `q` is 0. The clear takes effect at once, without waiting for a clock edge, and it resets both stages of every cell.
- R2: While `clr_n` is held low across clock cycles, `q` stays 0 whatever the value of `cnt_en`.
- R3: `q` never changes at a rising clock edge. It can change only at a falling edge, or when the clear is asserted.
- R4: `cnt_en` is sampled at the rising edge. When it is 1 there, `q` shows the previous count plus one after the following falling edge.
- R5: When `cnt_en` is 0 at the rising edge, `q` keeps its value through the following falling edge.
- R6: The count wraps. When `q` is all ones (15 for the default width) and `cnt_en` is 1, the next falling edge gives 0.
- R7: After `clr_n` rises, the first rising edge that sees `cnt_en` high moves the count from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The front stage captures on the rising edge and the output stage updates on the falling edge. |
| clr_n | input | 1 | Asynchronous clear, active low. |
| cnt_en | input | 1 | Count enable, active high. |
| q | output | WIDTH | Count value, taken from the output stages. |

## Verification
The assertion that `q` is stable between a rising edge and the next falling edge takes for granted that `clr_n` is asserted and released only while the clock is low. Without that, a clear in the high phase would leave its rising-edge snapshot stale. The increment and hold checks take for granted that `cnt_en` is settled at each rising edge. The stimulus meets both conditions by changing `clr_n` and `cnt_en` only 1 ns after a falling edge, well clear of either edge.

// File: rtl/jk_ms_counter.sv
module jk_ms_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             cnt_en,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] j, k, mst, nxt;
  logic [WIDTH:0]   chain;

  assign chain[0] = cnt_en;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign chain[i+1] = chain[i] & q[i];
    assign j[i] = chain[i];
    assign k[i] = chain[i];
    assign nxt[i] = (j[i] & ~q[i]) | (~k[i] & q[i]);

    always_ff @(posedge clk or negedge clr_n)
      if (!clr_n) mst[i] <= 1'b0;
      else        mst[i] <= nxt[i];

    always_ff @(negedge clk or negedge clr_n)
      if (!clr_n) q[i] <= 1'b0;
      else        q[i] <= mst[i];
  end
endmodule

module jk_ms_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             cnt_en,
  input logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_at_rise;
  logic             snap_ok;

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n) begin
      q_at_rise <= '0;
      snap_ok   <= 1'b0;
    end else begin
      q_at_rise <= q;
      snap_ok   <= 1'b1;
    end

  AST_CLR_ZERO: assert property (@(posedge clk) !clr_n |-> q == '0) // R1
    else $error("clear did not zero the count");
  AST_CLR_HOLD: assert property (@(negedge clk) !clr_n |-> q == '0) // R2
    else $error("count moved during clear");
  AST_RISE_STABLE: assert property (@(negedge clk) disable iff (!clr_n) snap_ok |-> q == q_at_rise) // R3
    else $error("count changed in the high phase");
  AST_INC: assert property (@(posedge clk) disable iff (!clr_n) snap_ok && $past(cnt_en) |-> q == WIDTH'($past(q) + 1'b1)) // R4
    else $error("count did not increment");
  AST_HOLD: assert property (@(posedge clk) disable iff (!clr_n) snap_ok && !$past(cnt_en) |-> q == $past(q)) // R5
    else $error("count moved while disabled");
  AST_WRAP: assert property (@(posedge clk) disable iff (!clr_n) snap_ok && $past(cnt_en) && $past(q) == '1 |-> q == '0) // R6
    else $error("count did not wrap");
endmodule

bind jk_ms_counter jk_ms_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .clr_n(clr_n), .cnt_en(cnt_en), .q(q)
);

// File: tb/tb_jk_ms_counter.sv
`timescale 1ns/100ps
module tb_jk_ms_counter;
  localparam int W = 4;
  logic clk = 1'b0, clr_n = 1'b0, cnt_en = 1'b0;
  logic [W-1:0] q;
  int checks = 0, errors = 0;
  logic [W-1:0] exp_q = '0;
  logic [W-1:0] expq[$];
  string        tagq[$];
  logic [W-1:0] last_q = '0;
  bit           last_ok = 1'b0;
  bit           done = 1'b0;

  jk_ms_counter #(.WIDTH(W)) dut (.clk(clk), .clr_n(clr_n), .cnt_en(cnt_en), .q(q));

  always #2 clk = ~clk;

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit en, string tag);
    cnt_en = en;
    if (!clr_n) exp_q = '0;
    else if (en) exp_q = exp_q + 1'b1;
    expq.push_back(exp_q);
    tagq.push_back(tag);
    @(negedge clk); #1;
  endtask

  always @(negedge clk) begin
    #0.5;
    if (expq.size() > 0) check(tagq.pop_front(), q, expq.pop_front());
    last_q  = q;
    last_ok = clr_n;
  end

  always @(posedge clk) begin
    #0.5;
    if (clr_n && last_ok) check("R3 rising edge", q, last_q);
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: q=%0d expected completion", q);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 check("R1 reset", q, '0);
    @(negedge clk); #1;
    step(1'b1, "R2 held clear");
    step(1'b1, "R2 held clear");
    clr_n = 1'b1;
    exp_q = '0;
    step(1'b1, "R7 first count");
    for (int i = 0; i < 6; i++) step(1'b1, "R4 increment");
    step(1'b0, "R5 hold");
    step(1'b0, "R5 hold");
    step(1'b0, "R5 hold");
    for (int i = 0; i < 3; i++) begin
      step(1'b1, "R4 alternate");
      step(1'b0, "R5 alternate");
    end
    clr_n = 1'b0;
    #0.2 check("R1 async clear", q, '0);
    exp_q = '0;
    #0.8;
    step(1'b1, "R2 clear with enable");
    step(1'b0, "R2 clear without enable");
    clr_n = 1'b1;
    step(1'b0, "R5 hold after clear");
    step(1'b1, "R7 first count after clear");
    for (int i = 0; i < 14; i++) step(1'b1, (exp_q == '1) ? "R6 wrap" : "R4 increment");
    step(1'b1, (exp_q == '1) ? "R6 wrap" : "R4 increment");
    step(1'b1, "R4 after wrap");
    @(negedge clk); #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule